// File: doc/BRIEF.md
# Power-of-Two Rounding Approximate Multiplier

This block multiplies two 8-bit operands approximately. Each operand magnitude is replaced by the power of two nearest to it. The product is then rebuilt from three shifted terms and one subtraction, so no partial-product array is needed. For operands A and B with rounded values Ar and Br, the magnitude of the product is A·Br + Ar·B − Ar·Br. This differs from the exact product by (A−Ar)·(B−Br).

A mode input selects how the operands are read. In unsigned mode they are plain binary. In signed mode they are two's complement values: each is reduced to its magnitude, and the result is negated when the operand signs differ. The 16-bit result may be registered or combinational, chosen by a parameter. The block suits error-tolerant datapaths that trade accuracy for shifter-only arithmetic.

Top module: `rba_mult`

## Requirements
- R1: With `mode` = 0, both operands are unsigned values from 0 to 255, and `prod` is an unsigned 16-bit value.
- R2: With `mode` = 1, both operands are two's complement values. An operand with bit 7 set is replaced by its negation before rounding, and −128 gives a magnitude of 128.
- R3: A nonzero magnitude M rounds to the power of two nearest to it. When M lies exactly midway between two powers of two, it rounds to the larger one. A magnitude of 1 stays 1.
- R4: When either operand is zero, `prod` is zero in both modes.
- R5: For nonzero magnitudes A and B, the product magnitude equals A·Br + Ar·B − Ar·Br. This value always fits in 16 bits.
- R6: In signed mode the product is negative, in 16-bit two's complement, exactly when both operands are nonzero and their sign bits differ. In every other case the product is non-negative.
- R7: Operands 68 and 104 give 7168 in both modes. In signed mode, −68 and 104 give −7168.
- R8: With `REG_OUT` = 1, `prod` shows the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, `prod` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode | input | 1 | 0 = unsigned operands, 1 = two's complement operands |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| prod | output | 16 | Approximate product |

## Verification
The assertions take the operands to be stable across each rising clock edge, and take the mode bit to change only together with the operands. The sign checks rest on the approximate magnitude never being zero when both inputs are nonzero; R3 and R5 guarantee this. The bench drives every input at the falling edge and holds it for a full cycle. It sweeps every operand pair in both modes, so no operand combination the block accepts is left out.

// File: rtl/rba_pkg.sv
package rba_pkg;
   localparam int MAX_DATA_W = 16;

   typedef enum logic {
      MODE_UNSIGNED = 1'b0,
      MODE_SIGNED   = 1'b1
   } rba_mode_e;
endpackage

// File: rtl/rba_sign_abs.sv
// Sign detection and magnitude extraction for one operand.
module rba_sign_abs #(
   parameter int W = 8
) (
   input  logic         signed_mode,
   input  logic [W-1:0] x,
   output logic         neg,
   output logic [W-1:0] mag
);
   // The most negative value maps to 2^(W-1), which fits in W unsigned bits.
   always_comb begin
      neg = signed_mode & x[W-1];
      mag = neg ? (~x + W'(1)) : x;
   end
endmodule

// File: rtl/rba_round.sv
// Leading-one detection with round-half-up to the nearest power of two.
module rba_round #(
   parameter int W  = 8,
   parameter int SW = $clog2(W + 1)
) (
   input  logic [W-1:0]  mag,
   output logic          zero,
   output logic [SW-1:0] sh,
   output logic [W:0]    oh
);
   logic [SW-1:0] lead;
   logic          below;

   always_comb begin
      lead = '0;
      for (int i = 0; i < W; i++) begin
         if (mag[i]) lead = SW'(i);
      end
      below = (lead == '0) ? 1'b0 : mag[lead - SW'(1)];
      zero  = (mag == '0);
      sh    = zero ? '0 : (lead + SW'(below));
      oh    = zero ? '0 : ((W + 1)'(1) << sh);
   end
endmodule

// File: rtl/rba_shift_core.sv
// Three shifted terms and one subtraction: A*Br + Ar*B - Ar*Br.
module rba_shift_core #(
   parameter int W     = 8,
   parameter int SW    = $clog2(W + 1),
   parameter int ACC_W = 2 * W + 2
) (
   input  logic [W-1:0]     mag_a,
   input  logic [W-1:0]     mag_b,
   input  logic [SW-1:0]    sh_a,
   input  logic [SW-1:0]    sh_b,
   input  logic [W:0]       oh_a,
   input  logic             zero_a,
   input  logic             zero_b,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] t_ab, t_ba, t_rr;

   always_comb begin
      t_ab = ACC_W'(mag_a) << sh_b;
      t_ba = ACC_W'(mag_b) << sh_a;
      t_rr = ACC_W'(oh_a)  << sh_b;
      acc  = (zero_a | zero_b) ? '0 : (t_ab + t_ba - t_rr);
   end
endmodule

// File: rtl/rba_mult.sv
module rba_mult #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode,
   input  logic [DATA_W-1:0]     op_a,
   input  logic [DATA_W-1:0]     op_b,
   output logic [2*DATA_W-1:0]   prod
);
   localparam int SW    = $clog2(DATA_W + 1);
   localparam int PW    = 2 * DATA_W;
   localparam int ACC_W = PW + 2;

   generate
      if (DATA_W < 2 || DATA_W > rba_pkg::MAX_DATA_W) begin : g_bad_width
         $error("rba_mult: DATA_W out of supported range");
      end
   endgenerate

   logic              signed_mode;
   logic [DATA_W-1:0] op   [2];
   logic [DATA_W-1:0] mag  [2];
   logic              neg  [2];
   logic              zero [2];
   logic [SW-1:0]     sh   [2];
   logic [DATA_W:0]   oh   [2];
   logic [ACC_W-1:0]  acc;
   logic              neg_res;
   logic [PW-1:0]     res;

   assign signed_mode = (rba_pkg::rba_mode_e'(mode) == rba_pkg::MODE_SIGNED);
   assign op[0] = op_a;
   assign op[1] = op_b;

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      rba_sign_abs #(.W(DATA_W)) u_abs (
         .signed_mode (signed_mode),
         .x           (op[g]),
         .neg         (neg[g]),
         .mag         (mag[g])
      );
      rba_round #(.W(DATA_W), .SW(SW)) u_rnd (
         .mag  (mag[g]),
         .zero (zero[g]),
         .sh   (sh[g]),
         .oh   (oh[g])
      );
   end

   rba_shift_core #(.W(DATA_W), .SW(SW), .ACC_W(ACC_W)) u_core (
      .mag_a  (mag[0]),
      .mag_b  (mag[1]),
      .sh_a   (sh[0]),
      .sh_b   (sh[1]),
      .oh_a   (oh[0]),
      .zero_a (zero[0]),
      .zero_b (zero[1]),
      .acc    (acc)
   );

   // Sign set: negate when the extracted signs differ.
   always_comb begin
      neg_res = neg[0] ^ neg[1];
      res     = neg_res ? (~acc[PW-1:0] + PW'(1)) : acc[PW-1:0];
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod <= '0;
            else        prod <= res;
         end
      end else begin : g_comb_out
         assign prod = res;
      end
   endgenerate
endmodule

// File: rtl/rba_mult_chk.sv
module rba_mult_chk #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   parameter int ACC_W   = 2 * DATA_W + 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mode,
   input logic [DATA_W-1:0]   op_a,
   input logic [DATA_W-1:0]   op_b,
   input logic [2*DATA_W-1:0] prod,
   input logic [DATA_W:0]     oh_a,
   input logic [DATA_W:0]     oh_b,
   input logic                za,
   input logic                zb,
   input logic [ACC_W-1:0]    acc
);
   localparam int PW = 2 * DATA_W;

   logic any_zero, diff_sign;
   assign any_zero  = (op_a == '0) || (op_b == '0);
   assign diff_sign = mode && (op_a[DATA_W-1] != op_b[DATA_W-1]);

   // R3: rounded operands are a single power of two, or none when zero
   p_onehot_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oh_a) && ((oh_a == '0) == za));
   p_onehot_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(oh_b) && ((oh_b == '0) == zb));

   // R5: the magnitude never exceeds the product width
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc[ACC_W-1:PW] == '0);

   generate
      if (REG_OUT) begin : g_seq
         p_zero_prod_r4: assert property (@(posedge clk) disable iff (!rst_n)
            any_zero |=> (prod == '0));
         p_neg_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_zero && diff_sign) |=> prod[PW-1]);
         p_pos_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_zero && !diff_sign && mode) |=> (!prod[PW-1] && prod != '0));
      end else begin : g_comb
         p_zero_prod_r4: assert property (@(posedge clk) disable iff (!rst_n)
            any_zero |-> (prod == '0));
         p_neg_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_zero && diff_sign) |-> prod[PW-1]);
         p_pos_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_zero && !diff_sign && mode) |-> (!prod[PW-1] && prod != '0));
      end
   endgenerate
endmodule

bind rba_mult rba_mult_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .mode  (mode),
   .op_a  (op_a),
   .op_b  (op_b),
   .prod  (prod),
   .oh_a  (oh[0]),
   .oh_b  (oh[1]),
   .za    (zero[0]),
   .zb    (zero[1]),
   .acc   (acc)
);

// File: tb/rba_mult_test.sv
module rba_mult_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic [7:0]  op_a = '0;
   logic [7:0]  op_b = '0;
   logic [15:0] prod;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rba_mult #(.DATA_W(8), .REG_OUT(1'b1)) uut (
      .clk (clk), .rst_n (rst_n), .mode (mode),
      .op_a (op_a), .op_b (op_b), .prod (prod)
   );

   // Nearest power of two by distance, ties to the larger one (R3).
   function automatic int ref_round(input int m);
      int best = 0;
      int bestd = 1 << 20;
      for (int p = 0; p <= 9; p++) begin
         int d = (m > (1 << p)) ? m - (1 << p) : (1 << p) - m;
         if (d <= bestd) begin
            bestd = d;
            best  = 1 << p;
         end
      end
      return best;
   endfunction

   function automatic logic [15:0] ref_prod(input logic md, input logic [7:0] a, input logic [7:0] b);
      int ma, mb, ra, rb, r;
      bit na, nb;
      na = md && a[7];
      nb = md && b[7];
      ma = na ? 256 - int'(a) : int'(a);
      mb = nb ? 256 - int'(b) : int'(b);
      if (ma == 0 || mb == 0) return 16'd0;
      ra = ref_round(ma);
      rb = ref_round(mb);
      r  = ma * rb + ra * mb - ra * rb;
      if (na != nb) r = -r;
      return 16'(r);
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: mode=%0d a=%0d b=%0d got=%0d expected=%0d",
                  tag, mode, op_a, op_b, got, exp);
      end
   endtask

   // Drive at negedge, result visible after the next posedge (R8).
   task automatic apply(input string tag, input logic md, input logic [7:0] a, input logic [7:0] b);
      mode = md; op_a = a; op_b = b;
      @(posedge clk);
      @(negedge clk);
      check(tag, prod, ref_prod(md, a, b));
   endtask

   task automatic apply_exp(input string tag, input logic md, input logic [7:0] a,
                            input logic [7:0] b, input logic [15:0] exp);
      mode = md; op_a = a; op_b = b;
      @(posedge clk);
      @(negedge clk);
      check(tag, prod, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0417));
      @(negedge clk);
      mode = 1'b1; op_a = 8'd68; op_b = 8'd104;
      repeat (3) @(negedge clk);
      check("R8 reset holds output at zero", prod, 16'd0);
      rst_n = 1'b1;

      // Directed corners
      apply_exp("R7 unsigned 68x104", 1'b0, 8'd68, 8'd104, 16'd7168);
      apply_exp("R7 signed 68x104", 1'b1, 8'd68, 8'd104, 16'd7168);
      apply_exp("R7 signed -68x104", 1'b1, 8'hBC, 8'd104, 16'hE400);
      apply_exp("R4 zero a unsigned", 1'b0, 8'd0, 8'd200, 16'd0);
      apply_exp("R4 zero b signed", 1'b1, 8'h85, 8'd0, 16'd0);
      apply_exp("R2 -128 x -128", 1'b1, 8'h80, 8'h80, 16'd16384);
      apply_exp("R2 -128 x 1", 1'b1, 8'h80, 8'd1, 16'hFF80);
      apply_exp("R3 tie 3x3 rounds up", 1'b0, 8'd3, 8'd3, 16'd8);
      apply_exp("R3 1x1 stays exact", 1'b0, 8'd1, 8'd1, 16'd1);
      apply_exp("R1 unsigned 255x255", 1'b0, 8'd255, 8'd255, 16'd65024);
      apply_exp("R6 signed -1 x -1", 1'b1, 8'hFF, 8'hFF, 16'd1);
      apply_exp("R6 signed 5 x -7", 1'b1, 8'd5, 8'hF9, 16'hFFDC);

      // Constrained random
      for (int i = 0; i < 3000; i++) begin
         logic md = 1'($urandom);
         apply(md ? "R6 random signed" : "R1 random unsigned",
               md, 8'($urandom), 8'($urandom));
      end

      // Exhaustive sweep of both modes (R5)
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               apply("R5 sweep", 1'(m), 8'(a), 8'(b));
            end
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule